// File: doc/BRIEF.md
# SIMD Conversion Fault Checker

This block decides which fault, if any, a packed floating-point conversion instruction must raise before it is allowed to retire. The decode and address stages hand it a snapshot of the instruction's context: the operating mode, a few control-register bits, the feature-present flag, the lock prefix, the memory operand's effective address and width, a precomputed segment-limit verdict, and whether the numeric unit reports an unmasked SIMD exception. The block resolves these into a single fault code.

All conditions are evaluated together in one combinational tree with a fixed priority. The winning code is registered, so the result appears one clock after the request strobe and is qualified by a valid flag. Page-fault detection, address translation and the delivery of the fault happen outside this block.

Top module: `simd_fault_check`

## Requirements
- R1: `flt_valid` is high in the cycle after each cycle with `req` high, and low after every cycle with `req` low.
- R2: The fault code is encoded as 0 none, 1 general protection, 2 stack, 3 device not available, 4 invalid opcode, 5 SIMD numeric. It reads 0 whenever `flt_valid` is low, and also when a request meets no fault condition.
- R3: A lock prefix gives code 4, whatever else holds.
- R4: Code 4 is also raised when `cr0_em` is 1, when `cr4_fxsr` is 0, or when `feat_ok` is 0.
- R5: When `cr0_ts` is 1 and neither R3 nor R4 applies, the code is 3.
- R6: A 16-byte memory operand (`op_wide`=1) whose address bits [3:0] are not all zero gives code 1 in every mode. An 8-byte operand is not checked for alignment.
- R7: In modes 1 (real) and 2 (virtual-8086), a memory operand whose last byte lies above FFFFh gives code 1.
- R8: In modes 0 (protected) and 3 (compatibility), `seg_bad` gives code 2 when `use_ss` is 1 and code 1 otherwise. `seg_bad` is ignored in modes 1, 2 and 4.
- R9: In mode 4 (64-bit), an address whose bits [63:47] are not all equal gives code 2 when `use_ss` is 1 and code 1 otherwise.
- R10: The address checks of R6 to R9 apply only when `mem_op` is 1.
- R11: An unmasked SIMD exception (`simd_exc`) gives code 5 when `cr4_xmm_exc` is 1 and code 4 when it is 0.
- R12: The priority is: R3/R4, then R5, then the alignment check, then the segment, range and canonical checks, then R11.
- R13: Mode values 5 to 7 follow the protected-mode rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Evaluate the inputs in this cycle |
| mode | input | 3 | 0 protected, 1 real, 2 virtual-8086, 3 compatibility, 4 64-bit |
| cr0_ts | input | 1 | Task-switched control bit |
| cr0_em | input | 1 | Emulation control bit |
| cr4_fxsr | input | 1 | OS support for extended state save |
| cr4_xmm_exc | input | 1 | OS handles SIMD numeric faults |
| feat_ok | input | 1 | Instruction set extension is present |
| lock_pfx | input | 1 | Lock prefix present |
| mem_op | input | 1 | Source operand is in memory |
| op_wide | input | 1 | 1 = 16-byte operand, 0 = 8-byte operand |
| ea | input | ADDR_W | Effective address of the memory operand |
| seg_bad | input | 1 | Segment-limit or selector check failed |
| use_ss | input | 1 | Operand references the stack segment |
| simd_exc | input | 1 | Unmasked SIMD floating-point exception pending |
| flt_valid | output | 1 | Result strobe |
| flt_code | output | 3 | Fault code, encoded as in R2 |

## Verification
Every result is due exactly one clock after the cycle in which `req` was high. The driver applies the inputs just after a falling edge and pushes the expected code into a queue. The monitor samples on the next falling edge, so each registered output is read half a period after the edge that produced it. Any valid strobe that arrives with no pending expectation counts as a failure, and so does an expectation still pending at the end of the run. Idle cycles are checked directly for a low strobe and a zero code.

// File: rtl/simd_fault_check.sv
module simd_fault_check #(
  parameter int ADDR_W      = 64,
  parameter int VA_BITS     = 48,
  parameter int ALIGN_BYTES = 16,
  parameter int WIDE_BYTES  = 16,
  parameter int NARROW_BYTES = 8,
  parameter longint unsigned REAL_LIMIT = 64'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        mode,
  input  logic              cr0_ts,
  input  logic              cr0_em,
  input  logic              cr4_fxsr,
  input  logic              cr4_xmm_exc,
  input  logic              feat_ok,
  input  logic              lock_pfx,
  input  logic              mem_op,
  input  logic              op_wide,
  input  logic [ADDR_W-1:0] ea,
  input  logic              seg_bad,
  input  logic              use_ss,
  input  logic              simd_exc,
  output logic              flt_valid,
  output logic [2:0]        flt_code
);

  localparam int ALIGN_LG = $clog2(ALIGN_BYTES);
  localparam int HI_W     = ADDR_W - VA_BITS + 1;

  localparam logic [2:0] F_NONE = 3'd0;
  localparam logic [2:0] F_GP   = 3'd1;
  localparam logic [2:0] F_SS   = 3'd2;
  localparam logic [2:0] F_NM   = 3'd3;
  localparam logic [2:0] F_UD   = 3'd4;
  localparam logic [2:0] F_XM   = 3'd5;

  localparam logic [2:0] M_REAL = 3'd1;
  localparam logic [2:0] M_V86  = 3'd2;
  localparam logic [2:0] M_LONG = 3'd4;

  localparam logic [ADDR_W:0] LIMIT    = (ADDR_W+1)'(REAL_LIMIT);
  localparam logic [ADDR_W:0] WIDE_M1  = (ADDR_W+1)'(WIDE_BYTES - 1);
  localparam logic [ADDR_W:0] NARW_M1  = (ADDR_W+1)'(NARROW_BYTES - 1);

  logic              real_like, long_md, prot_like;
  logic              bad_ctl, misalign, real_oob, canon, seg_hit;
  logic [ADDR_W:0]   last_byte;
  logic [HI_W-1:0]   hi_bits;
  logic [2:0]        code_nx;

  assign real_like = (mode == M_REAL) || (mode == M_V86);
  assign long_md   = (mode == M_LONG);
  assign prot_like = !real_like && !long_md;

  assign bad_ctl   = lock_pfx || cr0_em || !cr4_fxsr || !feat_ok;
  assign misalign  = op_wide && (ea[ALIGN_LG-1:0] != '0);
  assign last_byte = {1'b0, ea} + (op_wide ? WIDE_M1 : NARW_M1);
  assign real_oob  = last_byte > LIMIT;
  assign hi_bits   = ea[ADDR_W-1:VA_BITS-1];
  assign canon     = (&hi_bits) || !(|hi_bits);
  assign seg_hit   = (prot_like && seg_bad) || (long_md && !canon);

  always_comb begin
    code_nx = F_NONE;
    if (bad_ctl)                        code_nx = F_UD;
    else if (cr0_ts)                    code_nx = F_NM;
    else if (mem_op && misalign)        code_nx = F_GP;
    else if (mem_op && seg_hit)         code_nx = use_ss ? F_SS : F_GP;
    else if (mem_op && real_like && real_oob) code_nx = F_GP;
    else if (simd_exc)                  code_nx = cr4_xmm_exc ? F_XM : F_UD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_code  <= F_NONE;
    end else begin
      flt_valid <= req;
      flt_code  <= req ? code_nx : F_NONE;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> flt_valid); // R1
  AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !flt_valid); // R1
  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |-> flt_code == F_NONE); // R2
  AST_LOCK_IS_UD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && lock_pfx) |=> flt_code == F_UD); // R3
  AST_TS_IS_NM: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cr0_ts && !lock_pfx && !cr0_em && cr4_fxsr && feat_ok) |=> flt_code == F_NM); // R5
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    flt_code <= F_XM); // R2

endmodule

// File: tb/tb_simd_fault_check.sv
module tb_simd_fault_check;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode;
  logic        cr0_ts, cr0_em, cr4_fxsr, cr4_xmm_exc, feat_ok, lock_pfx;
  logic        mem_op, op_wide, seg_bad, use_ss, simd_exc;
  logic [63:0] ea;
  logic        flt_valid;
  logic [2:0]  flt_code;

  typedef struct { logic [2:0] code; string tag; } exp_t;
  exp_t exp_q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fault_check dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .cr0_ts(cr0_ts), .cr0_em(cr0_em), .cr4_fxsr(cr4_fxsr), .cr4_xmm_exc(cr4_xmm_exc),
    .feat_ok(feat_ok), .lock_pfx(lock_pfx), .mem_op(mem_op), .op_wide(op_wide),
    .ea(ea), .seg_bad(seg_bad), .use_ss(use_ss), .simd_exc(simd_exc),
    .flt_valid(flt_valid), .flt_code(flt_code));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clean();
    mode = 3'd0; cr0_ts = 0; cr0_em = 0; cr4_fxsr = 1; cr4_xmm_exc = 1; feat_ok = 1;
    lock_pfx = 0; mem_op = 0; op_wide = 1; ea = 64'h1000; seg_bad = 0; use_ss = 0;
    simd_exc = 0;
  endtask

  task automatic send(input logic [2:0] expc, input string tag);
    exp_t e;
    req = 1'b1;
    e.code = expc; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req = 1'b0;
    clean();
  endtask

  always @(negedge clk) begin
    if (rst_n && flt_valid) begin
      if (exp_q.size() == 0) chk(0, "R1 unexpected strobe", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(flt_code == e.code, e.tag, flt_code, e.code);
      end
    end
  end

  task automatic finish_run();
    chk(exp_q.size() == 0, "R1 missing results", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 1, 0);
      finish_run();
    end
  end

  initial begin
    clean();
    repeat (3) @(negedge clk);
    chk(flt_valid == 0 && flt_code == 0, "R2 reset state", {flt_valid, flt_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(3'd0, "R2 clean request");
    @(negedge clk);
    chk(flt_valid == 0, "R1 idle strobe low", flt_valid, 0);
    chk(flt_code == 0, "R2 idle code zero", flt_code, 0);

    lock_pfx = 1; cr0_ts = 1; simd_exc = 1; mem_op = 1; ea = 64'h1004; send(3'd4, "R3 lock wins");
    cr0_em = 1; send(3'd4, "R4 emulate bit");
    cr4_fxsr = 0; send(3'd4, "R4 fxsr clear");
    feat_ok = 0; cr0_ts = 1; send(3'd4, "R4 feature absent over ts");
    cr0_ts = 1; mem_op = 1; ea = 64'h1008; seg_bad = 1; send(3'd3, "R5 ts over memory");
    mem_op = 1; ea = 64'h1008; send(3'd1, "R6 misaligned protected");
    mode = 3'd4; mem_op = 1; ea = 64'h1008; send(3'd1, "R6 misaligned 64-bit");
    mode = 3'd1; mem_op = 1; ea = 64'h0101; send(3'd1, "R6 misaligned real");
    mem_op = 1; op_wide = 0; ea = 64'h1008; send(3'd0, "R6 narrow not aligned-checked");
    mem_op = 0; ea = 64'h1003; seg_bad = 1; send(3'd0, "R10 no memory operand");
    mode = 3'd1; mem_op = 1; ea = 64'hFFF0; send(3'd0, "R7 real top fits");
    mode = 3'd1; mem_op = 1; ea = 64'h10000; send(3'd1, "R7 real above limit");
    mode = 3'd1; mem_op = 1; op_wide = 0; ea = 64'hFFF8; send(3'd0, "R7 narrow fits");
    mode = 3'd1; mem_op = 1; op_wide = 0; ea = 64'hFFFC; send(3'd1, "R7 narrow straddles");
    mode = 3'd2; mem_op = 1; ea = 64'h10000; send(3'd1, "R7 v86 above limit");
    mem_op = 1; seg_bad = 1; use_ss = 1; send(3'd2, "R8 protected stack");
    mem_op = 1; seg_bad = 1; send(3'd1, "R8 protected data");
    mode = 3'd3; mem_op = 1; seg_bad = 1; use_ss = 1; send(3'd2, "R8 compat stack");
    mode = 3'd1; mem_op = 1; seg_bad = 1; send(3'd0, "R8 real ignores seg_bad");
    mode = 3'd4; mem_op = 1; seg_bad = 1; send(3'd0, "R8 64-bit ignores seg_bad");
    mode = 3'd4; mem_op = 1; ea = 64'h0000_8000_0000_0000; send(3'd1, "R9 noncanonical data");
    mode = 3'd4; mem_op = 1; use_ss = 1; ea = 64'h0001_0000_0000_0000; send(3'd2, "R9 noncanonical stack");
    mode = 3'd4; mem_op = 1; ea = 64'hFFFF_8000_0000_0000; send(3'd0, "R9 canonical high");
    mode = 3'd0; mem_op = 1; ea = 64'h0000_8000_0000_0000; send(3'd0, "R9 protected no canonical check");
    simd_exc = 1; send(3'd5, "R11 numeric to XM");
    simd_exc = 1; cr4_xmm_exc = 0; send(3'd4, "R11 numeric to UD");
    simd_exc = 1; mem_op = 1; seg_bad = 1; use_ss = 1; send(3'd2, "R12 segment over numeric");
    mem_op = 1; ea = 64'h1008; seg_bad = 1; use_ss = 1; send(3'd1, "R12 alignment over segment");
    mode = 3'd6; mem_op = 1; seg_bad = 1; send(3'd1, "R13 reserved mode as protected");
    mode = 3'd7; mem_op = 1; ea = 64'h20000; send(3'd0, "R13 reserved mode no range check");

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule